// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets a processor run Clause 22 management reads and writes on external PHYs through a 32-bit register bus. Software loads the PHY and register numbers into an address word. For a write it also loads a 16-bit value. It then writes a command word that holds a start strobe and an access code. The block builds the whole frame: 32 preamble ones, start 01, opcode, both addresses, turnaround and 16 data bits, most significant bit first.

The block divides the system clock down to produce MDC. It drives MDIO through a data/enable pair that a pad cell resolves. A busy flag in the command word stays set for the whole frame, and software polls it. When busy clears after a read, software fetches the captured value from the read-data word. The MDC half period is a parameter. It is chosen so that one frame lasts a few hundred microseconds.

The register bank uses byte offsets 0x40 (configuration), 0x44 (address), 0x48 (write data), 0x4C (read data) and 0x50 (command/status). Any other offset reads as zero.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The configuration word at offset 0x40 stores any 32-bit value written to it, including 0x150FF, and reads it back unchanged.
- R2: The address word at 0x44 keeps written bits [12:8] as the PHY address and bits [4:0] as the register number. All its other bits read as zero.
- R3: The write-data word at 0x48 keeps written bits [15:0], and bits [31:16] read as zero.
- R4: Busy (bit 16 of 0x50) reads 1 from the cycle after a start command until 128*HALF_DIV clock cycles have passed, then reads 0. Start (bit 8) always reads 0, and bits [1:0] read back the last accepted access code.
- R5: A write (access code 1 in bits [1:0] of 0x50, with bit 8 set) sends 32 ones, 01, 01, the PHY address, the register number, 10, and the write data, all MSB first. MDIO is driven for all 64 bits.
- R6: A read (access code 0) sends 32 ones, 01, 10, the PHY address and the register number. It then releases MDIO for the turnaround and the 16 data bits. It samples MDIO on each rising MDC edge of the data bits, and the value lands in the read-data word at 0x4C.
- R7: While busy is set, command writes are ignored and changes to the address or write-data words leave the frame in progress unchanged. Those words still take the new values for later frames.
- R8: Between frames, MDC stays low and MDIO is not driven.
- R9: After reset, every register reads zero, busy is clear, MDC is low and MDIO is released.
- R10: The read-data word changes only when a read frame completes. A write frame leaves it holding the last captured value.
- R11: A command write with bit 8 clear, or with bit 1 of the access code set (codes 2 and 3), starts no frame.
- R12: Each MDC high phase and each MDC low phase inside a frame lasts HALF_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | ADDR_W | Byte offset of the register being accessed |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO drive enable; low means released |
| mdio_i | input | 1 | Resolved MDIO line level |

## Verification
Assertions check several rules on every cycle:
- MDC is low and MDIO is released whenever no frame runs.
- The master never drives the line during the release window of a read.
- A frame ends only after the falling MDC edge of its last bit.
- The read-data word moves only when a read completes.
- A command write refused for a bad code or a clear start bit never raises busy.
- The accepted access code does not change while busy.

Only the bench scenarios can show the rest. These are frame contents on the line bit by bit, the exact busy length and MDC phase widths, and the values captured from a responding PHY model. They also include the behaviour of writes issued during a frame, which the bench follows across the whole frame and the next readback.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Frame layout, in MDC bit positions counted from the first preamble bit
  localparam int unsigned FRAME_BITS    = 64;
  localparam int unsigned PREAMBLE_BITS = 32;
  localparam int unsigned TA_FIRST      = 46;
  localparam int unsigned DATA_FIRST    = 48;
  localparam int unsigned DATA_W        = 16;
  localparam int unsigned FIELD_W       = 5;

  // Register byte offsets seen by software
  localparam logic [7:0] OFS_CFG   = 8'h40;
  localparam logic [7:0] OFS_ADDR  = 8'h44;
  localparam logic [7:0] OFS_WDATA = 8'h48;
  localparam logic [7:0] OFS_RDATA = 8'h4C;
  localparam logic [7:0] OFS_CMD   = 8'h50;

  localparam int unsigned START_BIT = 8;
  localparam int unsigned BUSY_BIT  = 16;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1
  } acc_code_e;

  typedef struct packed {
    logic               is_write;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regnum;
    logic [DATA_W-1:0]  data;
  } mdio_req_t;

endpackage

// File: rtl/mdio_regbank.sv
module mdio_regbank
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_value,
  output logic              launch,
  output mdio_req_t         req
);

  logic [31:0]        cfg_q, cfg_d;
  logic [FIELD_W-1:0] phy_q, phy_d;
  logic [FIELD_W-1:0] regn_q, regn_d;
  logic [DATA_W-1:0]  wdata_q, wdata_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic [1:0]         code_q, code_d;

  logic sel_cfg, sel_addr, sel_wdata, sel_rdata, sel_cmd;

  assign sel_cfg   = (reg_addr == ADDR_W'(OFS_CFG));
  assign sel_addr  = (reg_addr == ADDR_W'(OFS_ADDR));
  assign sel_wdata = (reg_addr == ADDR_W'(OFS_WDATA));
  assign sel_rdata = (reg_addr == ADDR_W'(OFS_RDATA));
  assign sel_cmd   = (reg_addr == ADDR_W'(OFS_CMD));

  // A start is accepted only when idle and the access code is read or write
  assign launch = reg_we && sel_cmd && reg_wdata[START_BIT] && !busy && !reg_wdata[1];

  assign req.is_write = reg_wdata[0];
  assign req.phy      = phy_q;
  assign req.regnum   = regn_q;
  assign req.data     = wdata_q;

  always_comb begin
    cfg_d   = cfg_q;
    phy_d   = phy_q;
    regn_d  = regn_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    code_d  = code_q;
    if (reg_we && sel_cfg)   cfg_d = reg_wdata;
    if (reg_we && sel_addr) begin
      phy_d  = reg_wdata[12:8];
      regn_d = reg_wdata[4:0];
    end
    if (reg_we && sel_wdata) wdata_d = reg_wdata[DATA_W-1:0];
    if (launch)              code_d  = reg_wdata[1:0];
    if (rd_done)             rdata_d = rd_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      phy_q   <= '0;
      regn_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      code_q  <= '0;
    end else begin
      cfg_q   <= cfg_d;
      phy_q   <= phy_d;
      regn_q  <= regn_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      code_q  <= code_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_cfg)        reg_rdata = cfg_q;
    else if (sel_addr)  reg_rdata = {19'b0, phy_q, 3'b0, regn_q};
    else if (sel_wdata) reg_rdata = {16'b0, wdata_q};
    else if (sel_rdata) reg_rdata = {16'b0, rdata_q};
    else if (sel_cmd)   reg_rdata = {15'b0, busy, 7'b0, 1'b0, 6'b0, code_q};
  end

  // R10: captured read data moves only when a read frame finishes
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> $stable(rdata_q));

  // R11: refused command writes never start a frame
  assert_no_bad_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel_cmd && (!reg_wdata[START_BIT] || reg_wdata[1]) && !busy) |=> !busy);

  // R7: a command written during a frame leaves the accepted code alone
  assert_cmd_ignored_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel_cmd && busy) |=> $stable(code_q));

endmodule

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int unsigned HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  mdio_req_t         req,
  input  logic              tick,
  input  logic              mdio_i,
  output logic              running,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_value
);

  localparam int unsigned BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] TA_POS   = BIT_W'(TA_FIRST);
  localparam logic [BIT_W-1:0] DATA_POS = BIT_W'(DATA_FIRST);

  logic                  running_q, running_d;
  logic                  mdc_q, mdc_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic                  wr_q, wr_d;
  logic [DATA_W-1:0]     rx_q, rx_d;

  logic rise_en, fall_en, last_fall;

  assign rise_en   = running_q && tick && !mdc_q;
  assign fall_en   = running_q && tick && mdc_q;
  assign last_fall = fall_en && (bit_q == LAST_BIT);

  always_comb begin
    running_d = running_q;
    mdc_d     = mdc_q;
    bit_d     = bit_q;
    tx_d      = tx_q;
    wr_d      = wr_q;
    rx_d      = rx_q;
    if (launch && !running_q) begin
      running_d = 1'b1;
      mdc_d     = 1'b0;
      bit_d     = '0;
      wr_d      = req.is_write;
      tx_d      = {{PREAMBLE_BITS{1'b1}}, 2'b01,
                   req.is_write ? 2'b01 : 2'b10,
                   req.phy, req.regnum,
                   req.is_write ? 2'b10 : 2'b11,
                   req.is_write ? req.data : {DATA_W{1'b1}}};
    end else if (rise_en) begin
      mdc_d = 1'b1;
      if (!wr_q && (bit_q >= DATA_POS)) rx_d = {rx_q[DATA_W-2:0], mdio_i};
    end else if (fall_en) begin
      mdc_d = 1'b0;
      if (last_fall) begin
        running_d = 1'b0;
      end else begin
        bit_d = bit_q + 1'b1;
        tx_d  = {tx_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      mdc_q     <= 1'b0;
      bit_q     <= '0;
      tx_q      <= '0;
      wr_q      <= 1'b0;
      rx_q      <= '0;
    end else begin
      running_q <= running_d;
      mdc_q     <= mdc_d;
      bit_q     <= bit_d;
      tx_q      <= tx_d;
      wr_q      <= wr_d;
      rx_q      <= rx_d;
    end
  end

  assign running  = running_q;
  assign mdc      = mdc_q;
  assign mdio_o   = tx_q[FRAME_BITS-1];
  assign mdio_oe  = running_q && (wr_q || (bit_q < TA_POS));
  assign rd_done  = last_fall && !wr_q;
  assign rd_value = rx_q;

  // R8: no clock and no drive between frames
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> (!mdc && !mdio_oe));

  // R6: the line stays released for turnaround and data of a read
  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !wr_q && (bit_q >= TA_POS)) |-> !mdio_oe);

  // R4: a frame ends only on the falling edge of its final bit
  assert_frame_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_q) |-> ($past(bit_q) == LAST_BIT && $past(mdc_q)));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned HALF_DIV = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  logic rst_meta_q, rst_sync_q;
  logic busy, launch, tick, rd_done;
  logic [DATA_W-1:0] rd_value;
  mdio_req_t req;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mdio_regbank #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .rd_done   (rd_done),
    .rd_value  (rd_value),
    .launch    (launch),
    .req       (req)
  );

  mdio_mdc_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .run   (busy),
    .tick  (tick)
  );

  mdio_frame_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .launch   (launch),
    .req      (req),
    .tick     (tick),
    .mdio_i   (mdio_i),
    .running  (busy),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_done  (rd_done),
    .rd_value (rd_value)
  );

endmodule

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;

  localparam int HALF = 4;
  localparam int TCLK = 8;

  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_en, phy_val;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  mdio_mgmt_master #(.ADDR_W(8), .HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  // Line with pull-up: master, else PHY model, else high
  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  function automatic logic [15:0] resp(input logic [4:0] p, input logic [4:0] r);
    return {p, 3'b101, r, 3'b011} ^ 16'h5A3C;
  endfunction

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, p, r, 2'b10, wr ? d : resp(p, r)};
  endfunction

  function automatic logic [63:0] exp_oe(input bit wr);
    return wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'b0};
  endfunction

  // PHY-side monitor and responder
  int          seen = 0;
  int          frames = 0;
  logic [63:0] fbits, fo, last_f, last_o;
  logic [15:0] rsp;
  time         hi_t, hi_len;

  always @(posedge mdc) begin
    fbits[63-seen] = mdio_i;
    fo[63-seen]    = mdio_oe;
    seen           = seen + 1;
    hi_t           = $time;
  end

  always @(negedge mdc) begin
    hi_len = $time - hi_t;
    if (seen == 47 && fbits[29:28] == 2'b10) begin
      rsp     = resp(fbits[27:23], fbits[22:18]);
      phy_en  = 1'b1;
      phy_val = 1'b0;
    end else if (seen >= 48 && seen <= 63 && phy_en) begin
      phy_val = rsp[63-seen];
    end else if (seen == 64) begin
      last_f = fbits;
      last_o = fo;
      frames = frames + 1;
      seen   = 0;
      phy_en = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Counts falling clock edges with busy set; call at a falling edge
  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    forever begin
      reg_read(8'h50, v);
      if (!v[16]) break;
      n++;
      if (n > 100000) break;
      @(negedge clk);
    end
  endtask

  logic [15:0] model_rd = 16'h0;

  task automatic do_txn(input bit wr, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    int n, f0;
    logic [31:0] v;
    f0 = frames;
    reg_write(8'h44, {19'h0, p, 3'b0, r});
    if (wr) reg_write(8'h48, {16'hDEAD, d});
    reg_write(8'h50, {23'h0, 1'b1, 7'h0, wr});
    wait_idle(n);
    chk(n == 128*HALF, "R4 busy length", n, 128*HALF);
    chk(frames == f0 + 1, "R4 one frame per start", frames, f0 + 1);
    chk(hi_len == HALF*TCLK, "R12 mdc phase", hi_len, HALF*TCLK);
    if (wr) begin
      chk(last_f == exp_frame(1, p, r, d), "R5 write frame", last_f, exp_frame(1, p, r, d));
      chk(last_o == exp_oe(1), "R5 write drive", last_o, exp_oe(1));
      reg_read(8'h4C, v);
      chk(v == {16'h0, model_rd}, "R10 rdata kept on write", v, {16'h0, model_rd});
    end else begin
      chk(last_f == exp_frame(0, p, r, d), "R6 read frame", last_f, exp_frame(0, p, r, d));
      chk(last_o == exp_oe(0), "R6 read release", last_o, exp_oe(0));
      model_rd = resp(p, r);
      reg_read(8'h4C, v);
      chk(v == {16'h0, model_rd}, "R6 read capture", v, {16'h0, model_rd});
    end
    reg_read(8'h50, v);
    chk(v == {30'h0, 1'b0, wr}, "R4 cmd readback", v, {30'h0, 1'b0, wr});
    chk(!mdc && !mdio_oe, "R8 idle line", {mdc, mdio_oe}, 2'b00);
  endtask

  initial begin
    #(TCLK*150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, f0;
    int unsigned seed;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 8'h0; reg_wdata = 32'h0;
    phy_en = 1'b0; phy_val = 1'b0;
    seed = $urandom(32'd20240501);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 reset state
    for (int k = 0; k < 5; k++) begin
      reg_read(8'h40 + 8'(4*k), v);
      chk(v == 32'h0, "R9 register reset", v, 0);
    end
    chk(!mdc && !mdio_oe, "R9 line reset", {mdc, mdio_oe}, 2'b00);

    // R1 configuration word
    reg_write(8'h40, 32'h0001_50FF);
    reg_read(8'h40, v);
    chk(v == 32'h0001_50FF, "R1 cfg hold", v, 32'h0001_50FF);
    reg_write(8'h40, 32'hA5A5_3C3C);
    reg_read(8'h40, v);
    chk(v == 32'hA5A5_3C3C, "R1 cfg any value", v, 32'hA5A5_3C3C);
    reg_write(8'h40, 32'h0001_50FF);

    // R2 / R3 field masking
    reg_write(8'h44, 32'hFFFF_FFFF);
    reg_read(8'h44, v);
    chk(v == 32'h0000_1F1F, "R2 addr fields", v, 32'h1F1F);
    reg_write(8'h48, 32'hFFFF_1234);
    reg_read(8'h48, v);
    chk(v == 32'h0000_1234, "R3 wdata field", v, 32'h1234);

    // R11 refused commands
    f0 = frames;
    reg_write(8'h50, 32'h0000_0001);
    repeat (3) @(negedge clk);
    reg_read(8'h50, v);
    chk(v[16] == 1'b0, "R11 no start bit", v, 0);
    reg_write(8'h50, 32'h0000_0102);
    repeat (3) @(negedge clk);
    reg_read(8'h50, v);
    chk(v[16] == 1'b0, "R11 bad code", v, 0);
    reg_write(8'h50, 32'h0000_0103);
    repeat (HALF*4) @(negedge clk);
    chk(frames == f0, "R11 no frame", frames, f0);

    // Directed corners on address extremes
    do_txn(1, 5'd0, 5'd0, 16'h0000);
    do_txn(1, 5'd31, 5'd31, 16'hFFFF);
    do_txn(0, 5'd31, 5'd0, 16'h0);
    do_txn(0, 5'd0, 5'd31, 16'h0);
    do_txn(1, 5'd10, 5'd21, 16'h8001);

    // R7 writes during a frame
    f0 = frames;
    reg_write(8'h44, {19'h0, 5'd3, 3'b0, 5'd9});
    reg_write(8'h48, 32'h0000_C0DE);
    reg_write(8'h50, 32'h0000_0101);
    repeat (40) @(negedge clk);
    reg_write(8'h50, 32'h0000_0100);
    reg_write(8'h44, {19'h0, 5'd17, 3'b0, 5'd2});
    reg_write(8'h48, 32'h0000_1111);
    reg_read(8'h50, v);
    chk(v[1:0] == 2'b01, "R7 code unchanged while busy", v, 1);
    wait_idle(n);
    chk(frames == f0 + 1, "R7 single frame", frames, f0 + 1);
    chk(last_f == exp_frame(1, 5'd3, 5'd9, 16'hC0DE), "R7 frame unchanged",
        last_f, exp_frame(1, 5'd3, 5'd9, 16'hC0DE));
    reg_read(8'h44, v);
    chk(v == {19'h0, 5'd17, 3'b0, 5'd2}, "R7 addr took new value", v, {19'h0, 5'd17, 3'b0, 5'd2});
    repeat (HALF*4) @(negedge clk);
    chk(frames == f0 + 1, "R7 no late frame", frames, f0 + 1);

    // Constrained random traffic
    for (int i = 0; i < 24; i++) begin
      bit wr;
      logic [4:0] p, r;
      logic [15:0] d;
      wr = 1'($urandom);
      p  = 5'($urandom);
      r  = 5'($urandom);
      d  = 16'($urandom);
      do_txn(wr, p, r, d);
    end

    reg_read(8'h40, v);
    chk(v == 32'h0001_50FF, "R1 cfg held after traffic", v, 32'h0001_50FF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule